// File: doc/BRIEF.md
# Accumulator Processing Element with Decimal Arithmetic

This block is a self-contained accumulator register with its own small arithmetic unit. Every clock it takes a 3-bit operation code from the current instruction word, a 16-bit value from the shared internal data bus, and the carry and zero flags held outside the block. It then updates its register and presents new carry and zero flags for the external flag storage to capture. It can load from the bus, place its value on the bus, add and subtract with carry, rotate through carry, and step up or down by one.

A decimal-mode input switches add and subtract to packed BCD arithmetic, one decimal digit per nibble. In that mode subtract uses the nines-complement of the operand. Subtract treats the carry as an inverted borrow, so a carry of 1 means "no borrow". The rotate moves a 17-bit ring made of the register and the carry. An `active` strobe shows whether this element does anything in the current cycle, so that throughput counters can add up the busy elements.

The flag outputs, the bus-drive enable and the active strobe are combinational in the current operation and register value. The register itself takes its new value on the next rising clock edge.

Top module: `acc_element`

## Requirements
- R1: While reset is asserted, and until the synchronised release has passed two rising edges, the accumulator reads 0x0000.
- R2: Operation 0 (hold) leaves the accumulator unchanged. It passes carry_in to carry_out and zero_in to zero_out, and keeps drive_en low.
- R3: Operation 4 (load) writes bus_in into the accumulator on the next edge and passes carry_in to carry_out. A bus value of 0x0000 therefore clears the accumulator and raises zero_out.
- R4: Operation 5 (store) is the only operation that raises drive_en. It leaves the accumulator unchanged and passes both flags through.
- R5: Operation 1 (add) with dec_mode low stores the low 16 bits of acc + bus_in + carry_in. carry_out is bit 16 of that sum.
- R6: Operation 2 (subtract) with dec_mode low stores acc + (bus_in XOR 0xFFFF) + carry_in. carry_out is 1 when no borrow occurred.
- R7: Operation 1 with dec_mode high treats both values as four packed BCD digits and stores the decimal sum modulo 10000. carry_out is 1 when the sum reached 10000.
- R8: Operation 2 with dec_mode high stores the decimal difference acc - bus_in - (1 - carry_in), wrapped modulo 10000. carry_out is 1 when the difference was not negative.
- R9: Operation 3 (rotate) moves the 17-bit ring {acc, carry} one place toward the LSB. The new acc is {carry_in, acc[15:1]} and carry_out is acc[0].
- R10: Operation 6 (increment) and operation 7 (decrement) are binary in both modes. Increment gives carry_out = 1 only when wrapping from 0xFFFF. Decrement gives carry_out = 0 only when wrapping from 0x0000.
- R11: For operations 1, 2, 3, 4, 6 and 7, zero_out is 1 exactly when the value about to be written into the accumulator is 0x0000.
- R12: active is 0 for operation 0 and 1 for every other operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op | input | 3 | Operation code from the instruction slice |
| dec_mode | input | 1 | 1 selects BCD add and subtract |
| bus_in | input | 16 | Internal data bus value |
| carry_in | input | 1 | Current accumulator carry flag |
| zero_in | input | 1 | Current accumulator zero flag |
| acc_q | output | 16 | Accumulator register value |
| drive_en | output | 1 | Request to place acc_q on the internal bus |
| carry_out | output | 1 | Next carry flag |
| zero_out | output | 1 | Next zero flag |
| active | output | 1 | Element performs a non-hold operation |

## Verification
The flags, drive_en and active depend on the current operation and register contents, so they are due in the same cycle as the operation. The bench samples them mid-cycle, after the inputs have settled and before the next rising edge. The new accumulator value is due one rising edge after the operation is presented, so it is compared at the following falling edge, just before the next operation is driven. After reset is released the bench waits for the two-stage release to pass before it starts issuing operations.

// File: rtl/acc_pe_pkg.sv
package acc_pe_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_ADC   = 3'd1,
    OP_SBC   = 3'd2,
    OP_RRC   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_INC   = 3'd6,
    OP_DEC   = 3'd7
  } acc_op_e;

  localparam int unsigned DIGIT_W = 4;
endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_q = stage_q[1];
endmodule

// File: rtl/acc_dual_adder.sv
module acc_dual_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         dec,
  output logic [W-1:0] sum,
  output logic         cout
);
  import acc_pe_pkg::*;
  localparam int unsigned DIGITS = W / DIGIT_W;

  logic [W:0]      bin_full;
  logic [W-1:0]    dec_sum;
  logic [DIGITS:0] dc;

  assign bin_full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign dc[0]    = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [DIGIT_W:0] raw;
    logic             fix;
    assign raw = {1'b0, a[g*DIGIT_W +: DIGIT_W]} + {1'b0, b[g*DIGIT_W +: DIGIT_W]}
               + {{DIGIT_W{1'b0}}, dc[g]};
    assign fix = (raw > 5'd9);
    assign dec_sum[g*DIGIT_W +: DIGIT_W] = fix ? (raw[DIGIT_W-1:0] + 4'd6) : raw[DIGIT_W-1:0];
    assign dc[g+1] = fix;
  end

  always_comb begin
    if (dec) begin
      sum  = dec_sum;
      cout = dc[DIGITS];
    end else begin
      sum  = bin_full[W-1:0];
      cout = bin_full[W];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int unsigned W = 16
) (
  input  logic [2:0]   op,
  input  logic         dec_mode,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] bus_in,
  input  logic         carry_in,
  input  logic         zero_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero_out,
  output logic         drive_en,
  output logic         active
);
  import acc_pe_pkg::*;
  localparam int unsigned DIGITS = W / DIGIT_W;

  acc_op_e     opc;
  logic [W-1:0] nines;
  logic [W-1:0] add_b;
  logic         add_c;
  logic         add_dec;
  logic [W-1:0] add_sum;
  logic         add_cout;

  assign opc = acc_op_e'(op);

  for (genvar g = 0; g < DIGITS; g++) begin : g_nines
    assign nines[g*DIGIT_W +: DIGIT_W] = 4'd9 - bus_in[g*DIGIT_W +: DIGIT_W];
  end

  always_comb begin
    add_b   = bus_in;
    add_c   = carry_in;
    add_dec = 1'b0;
    unique case (opc)
      OP_ADC: add_dec = dec_mode;
      OP_SBC: begin
        add_dec = dec_mode;
        add_b   = dec_mode ? nines : ~bus_in;
      end
      OP_INC: begin
        add_b = '0;
        add_c = 1'b1;
      end
      OP_DEC: begin
        add_b = '1;
        add_c = 1'b0;
      end
      default: ;
    endcase
  end

  acc_dual_adder #(.W(W)) u_adder (
    .a    (acc),
    .b    (add_b),
    .cin  (add_c),
    .dec  (add_dec),
    .sum  (add_sum),
    .cout (add_cout)
  );

  always_comb begin
    result    = acc;
    carry_out = carry_in;
    unique case (opc)
      OP_HOLD, OP_STORE: ;
      OP_LOAD: result = bus_in;
      OP_RRC: begin
        result    = {carry_in, acc[W-1:1]};
        carry_out = acc[0];
      end
      default: begin
        result    = add_sum;
        carry_out = add_cout;
      end
    endcase
  end

  always_comb begin
    drive_en = (opc == OP_STORE);
    active   = (opc != OP_HOLD);
    if (opc == OP_HOLD || opc == OP_STORE) zero_out = zero_in;
    else                                   zero_out = (result == '0);
  end
endmodule

// File: rtl/acc_element.sv
module acc_element #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic         dec_mode,
  input  logic [15:0]  bus_in,
  input  logic         carry_in,
  input  logic         zero_in,
  output logic [15:0]  acc_q,
  output logic         drive_en,
  output logic         carry_out,
  output logic         zero_out,
  output logic         active
);
  logic         rst_q;
  logic [W-1:0] acc_r;
  logic [W-1:0] acc_d;
  logic [W-1:0] alu_res;
  logic         acc_en;

  acc_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  acc_alu #(.W(W)) u_alu (
    .op        (op),
    .dec_mode  (dec_mode),
    .acc       (acc_r),
    .bus_in    (bus_in[W-1:0]),
    .carry_in  (carry_in),
    .zero_in   (zero_in),
    .result    (alu_res),
    .carry_out (carry_out),
    .zero_out  (zero_out),
    .drive_en  (drive_en),
    .active    (active)
  );

  assign acc_en = active;

  always_comb begin
    acc_d = acc_r;
    if (acc_en) acc_d = alu_res;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) acc_r <= '0;
    else        acc_r <= acc_d;
  end

  assign acc_q = acc_r;
endmodule

// File: rtl/acc_element_chk.sv
module acc_element_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_q,
  input logic [2:0]   op,
  input logic [15:0]  bus_in,
  input logic         carry_in,
  input logic         zero_in,
  input logic [15:0]  acc_q,
  input logic         drive_en,
  input logic         carry_out,
  input logic         zero_out,
  input logic         active
);
  import acc_pe_pkg::*;

  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_HOLD) |=> (acc_q == $past(acc_q)));

  a_r12_idle_passes: assert property (@(posedge clk) disable iff (!rst_q)
    !active |-> (zero_out == zero_in && carry_out == carry_in && !drive_en));

  a_r4_store_keeps: assert property (@(posedge clk) disable iff (!rst_q)
    drive_en |=> (acc_q == $past(acc_q)));

  a_r3_load_takes_bus: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_LOAD) |=> (acc_q == $past(bus_in)));

  a_r9_rrc_carry: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_RRC) |-> (carry_out == acc_q[0]));

  a_r9_rrc_ring: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_RRC) |=> (acc_q == {$past(carry_in), $past(acc_q[15:1])}));

  a_r10_inc_step: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_INC) |=> (acc_q == $past(acc_q) + 16'd1));

  a_r11_zero_matches: assert property (@(posedge clk) disable iff (!rst_q)
    (active && !drive_en) |=> ((acc_q == 16'd0) == $past(zero_out)));
endmodule

bind acc_element acc_element_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .op        (op),
  .bus_in    (bus_in),
  .carry_in  (carry_in),
  .zero_in   (zero_in),
  .acc_q     (acc_q),
  .drive_en  (drive_en),
  .carry_out (carry_out),
  .zero_out  (zero_out),
  .active    (active)
);

// File: tb/tb_acc_element.sv
module tb_acc_element;
  logic        clk;
  logic        rst_n;
  logic [2:0]  op;
  logic        dec_mode;
  logic [15:0] bus_in;
  logic        carry_in;
  logic        zero_in;
  logic [15:0] acc_q;
  logic        drive_en;
  logic        carry_out;
  logic        zero_out;
  logic        active;

  int checks = 0;
  int errors = 0;
  int ref_acc = 0;
  bit done = 0;

  acc_element dut (
    .clk(clk), .rst_n(rst_n), .op(op), .dec_mode(dec_mode), .bus_in(bus_in),
    .carry_in(carry_in), .zero_in(zero_in), .acc_q(acc_q), .drive_en(drive_en),
    .carry_out(carry_out), .zero_out(zero_out), .active(active)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int bcd2int(input int v);
    int r = 0;
    for (int i = 3; i >= 0; i--) r = r * 10 + ((v >> (4 * i)) & 15);
    return r;
  endfunction

  function automatic int int2bcd(input int v);
    int r = 0;
    for (int i = 0; i < 4; i++) begin
      r = r | ((v % 10) << (4 * i));
      v = v / 10;
    end
    return r;
  endfunction

  function automatic string req_of(input int o, input bit d);
    case (o)
      0: return "R2";
      1: return d ? "R7" : "R5";
      2: return d ? "R8" : "R6";
      3: return "R9";
      4: return "R3";
      5: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input int o, input bit d, input int b, input bit c, input bit z);
    int a, s, er, ec, ez;
    string rq;
    @(negedge clk);
    chk("R11", "acc_q before step", int'(acc_q), ref_acc);
    op = 3'(o); dec_mode = d; bus_in = 16'(b); carry_in = c; zero_in = z;
    a = ref_acc; ez = z; ec = c; er = a;
    rq = req_of(o, d);
    case (o)
      1: if (d) begin
           s = bcd2int(a) + bcd2int(b) + c;
           ec = (s >= 10000); er = int2bcd(s % 10000);
         end else begin
           s = a + b + c; er = s & 'hFFFF; ec = (s >> 16) & 1;
         end
      2: if (d) begin
           s = bcd2int(a) - bcd2int(b) - (1 - c);
           ec = (s >= 0); if (s < 0) s += 10000; er = int2bcd(s);
         end else begin
           s = a + ((~b) & 'hFFFF) + c; er = s & 'hFFFF; ec = (s >> 16) & 1;
         end
      3: begin er = (c << 15) | (a >> 1); ec = a & 1; end
      4: er = b;
      6: begin s = a + 1; er = s & 'hFFFF; ec = (s >> 16) & 1; end
      7: begin er = (a - 1) & 'hFFFF; ec = (a != 0); end
      default: ;
    endcase
    if (o != 0 && o != 5) ez = (er == 0);
    #2;
    chk(rq, "carry_out", int'(carry_out), ec);
    chk((o == 0 || o == 5) ? rq : "R11", "zero_out", int'(zero_out), ez);
    chk("R4", "drive_en", int'(drive_en), int'(o == 5));
    chk("R12", "active", int'(active), int'(o != 0));
    ref_acc = er;
  endtask

  function automatic int rand_bcd();
    int r = 0;
    for (int i = 0; i < 4; i++) r = r | (($urandom % 10) << (4 * i));
    return r;
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op = 3'd0; dec_mode = 1'b0; bus_in = 16'h0; carry_in = 1'b0; zero_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "acc_q in reset", int'(acc_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "acc_q during release", int'(acc_q), 0);
    repeat (3) @(negedge clk);
    // R2 / R12 hold with varied pass-through flags
    step(0, 0, 'hABCD, 1, 0);
    step(0, 1, 'h1234, 0, 1);
    // R3 load, including an idle bus reading zero
    step(4, 0, 'h1234, 1, 0);
    step(4, 0, 'h0000, 0, 0);
    step(4, 0, 'h00F0, 0, 1);
    // R4 store
    step(5, 0, 'h5555, 1, 1);
    step(5, 1, 'h0000, 0, 0);
    // R5 binary add
    step(4, 0, 'h1234, 0, 0);
    step(1, 0, 'h0001, 0, 0);
    step(4, 0, 'hFFFF, 0, 0);
    step(1, 0, 'h0001, 0, 0);
    step(1, 0, 'h0000, 1, 0);
    // R6 binary subtract
    step(4, 0, 'h0005, 0, 0);
    step(2, 0, 'h0003, 1, 0);
    step(4, 0, 'h0003, 0, 0);
    step(2, 0, 'h0005, 1, 0);
    step(4, 0, 'h0005, 0, 0);
    step(2, 0, 'h0003, 0, 0);
    // R7 decimal add
    step(4, 0, 'h0958, 0, 0);
    step(1, 1, 'h0047, 0, 0);
    step(4, 0, 'h9999, 0, 0);
    step(1, 1, 'h0001, 0, 0);
    // R8 decimal subtract
    step(4, 0, 'h1000, 0, 0);
    step(2, 1, 'h0001, 1, 0);
    step(4, 0, 'h0000, 0, 0);
    step(2, 1, 'h0001, 1, 0);
    step(2, 1, 'h0999, 0, 0);
    // R9 rotate through carry
    step(4, 0, 'h0003, 0, 0);
    step(3, 0, 'h0000, 1, 0);
    step(3, 0, 'h0000, 1, 0);
    step(4, 0, 'h0001, 0, 0);
    step(3, 0, 'h0000, 0, 0);
    // R10 increment / decrement, binary in both modes
    step(4, 0, 'hFFFF, 0, 0);
    step(6, 0, 'h0000, 0, 0);
    step(7, 0, 'h0000, 1, 0);
    step(4, 0, 'h0009, 0, 0);
    step(6, 1, 'h0000, 0, 0);
    step(7, 1, 'h0000, 0, 0);
    // mixed sequences
    for (int i = 0; i < 300; i++) begin
      int o = int'($urandom % 8);
      bit dd = (o == 1 || o == 2) ? bit'($urandom % 2) : 1'b0;
      if (dd) begin
        step(4, 0, rand_bcd(), bit'($urandom % 2), bit'($urandom % 2));
        step(o, 1, rand_bcd(), bit'($urandom % 2), bit'($urandom % 2));
      end else begin
        step(o, 0, int'($urandom % 65536), bit'($urandom % 2), bit'($urandom % 2));
      end
    end
    @(negedge clk);
    chk("R11", "final acc_q", int'(acc_q), ref_acc);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule